// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

A purely combinational 8-bit arithmetic and logic unit for the execute stage of a small microcontroller. The datapath supplies two operands (the second one may be a register or an immediate; the unit cannot tell the difference), the current carry and zero flags, and a 5-bit operation code. The unit returns an 8-bit result, a result-write strobe, six status flags and a six-bit mask. The mask tells the flag register which of those flags this operation updates. Flag bits outside the mask read 0.

The operations are:

- Arithmetic: add, add-with-carry, subtract, subtract-with-carry and the two compare forms.
- Logic: AND, OR, XOR and clear-bits.
- Complements: one's complement and two's complement.
- Increment and decrement.
- Shifts and rotates: logical shift left/right, arithmetic shift right, and rotate left/right through carry.
- Nibble swap.

Bit-set is issued as OR, and test or clear is issued as AND or XOR of a register with itself.

Flag vector positions, used by both `flags` and `flag_we`: bit 0 carry (C), bit 1 zero (Z), bit 2 negative (N), bit 3 overflow (V), bit 4 sign (S), bit 5 half-carry (H). In every case S equals N XOR V.

Operation codes: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 compare, 5 compare-with-carry, 6 AND, 7 OR, 8 XOR, 9 one's complement, 10 two's complement, 11 increment, 12 decrement, 13 logical shift right, 14 arithmetic shift right, 15 rotate right, 16 rotate left, 17 logical shift left, 18 nibble swap, 19 clear-bits. Codes 20 to 31 are unused.

Top module: `alu8_flags`

## Requirements
- R1: Codes 0 and 1 produce `a + b` (plus `c_in` for code 1). C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow. All six flags are written.
- R2: Codes 2 and 3 produce `a - b` (minus `c_in` for code 3). C is the borrow out of bit 7, H is the borrow out of bit 3, and V is signed overflow. All six flags are written. For code 3, Z is 1 only when the result is zero and `z_in` is 1.
- R3: Compare codes 4 and 5 give the same flags as codes 2 and 3 respectively, and hold `res_we` at 0.
- R4: AND (6), OR (7), XOR (8) and clear-bits (19, which is `a & ~b`) write only Z, N, V and S (mask 0x1E). V is 0.
- R5: One's complement (9) gives `0xFF - a` with C=1 and V=0, and writes every flag except H (mask 0x1F).
- R6: Two's complement (10) gives `0x00 - a` with C = (a != 0), H = (a[3:0] != 0) and V = (a == 0x80). All flags are written.
- R7: Increment (11) and decrement (12) write only Z, N, V and S. V is 1 only for an increment from 0x7F or a decrement from 0x80.
- R8: The shift and rotate codes produce the results below, each with mask 0x1F and V = N XOR C:
  - 13 logical shift right: `{0, a[7:1]}`, C = a[0].
  - 14 arithmetic shift right: `{a[7], a[7:1]}`, C = a[0].
  - 15 rotate right through carry: `{c_in, a[7:1]}`, C = a[0].
  - 16 rotate left through carry: `{a[6:0], c_in}`, C = a[7].
  - 17 logical shift left: `{a[6:0], 0}`, C = a[7].
- R9: Nibble swap (18) gives `{a[3:0], a[7:4]}` with `res_we` at 1 and a flag mask of 0.
- R10: S = N XOR V whenever V is written.
- R11: Unused codes 20 to 31 drive `res_we` = 0 and a flag mask of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 5 | Operation code |
| a | input | 8 | First operand (destination register value) |
| b | input | 8 | Second operand (register or immediate) |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| res | output | 8 | Result |
| res_we | output | 1 | Result should be written back |
| flags | output | 6 | New flags {H,S,V,N,Z,C}, 0 where not written |
| flag_we | output | 6 | Per-flag write mask, same bit order |

## Verification
The unit holds no state, so any wrong internal term shows on `res`, `flags` or `flag_we` in the same evaluation that presents the faulty operands. It never shows later. The faults that matter are wrong carry, borrow and overflow terms at bit 3 and bit 7, a mask that lets an operation disturb flags it must preserve, and a lost Z chain on the carry-in subtract forms. These show only for particular operand pairs, so every operation is swept over all values of the first operand, both carry and zero inputs, and a spread of second operands.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic [4:0] op,
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic       c_in,
  input  logic       z_in,
  output logic [7:0] res,
  output logic       res_we,
  output logic [5:0] flags,
  output logic [5:0] flag_we
);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_CP  = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7;
  localparam logic [4:0] OP_XOR = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11;
  localparam logic [4:0] OP_DEC = 5'd12, OP_LSR = 5'd13, OP_ASR = 5'd14, OP_ROR = 5'd15;
  localparam logic [4:0] OP_ROL = 5'd16, OP_LSL = 5'd17, OP_SWP = 5'd18, OP_CBR = 5'd19;
  localparam logic [5:0] M_ALL = 6'h3F, M_ZNVS = 6'h1E, M_NOH = 6'h1F;

  logic       cy_use, bw_use, sticky;
  logic [8:0] sum9, dif9;
  logic [4:0] sum5, dif5;
  logic [7:0] y;
  logic       c, h, v, n, z;
  logic [5:0] m;
  logic       is_logic;

  assign cy_use = (op == OP_ADC) & c_in;
  assign sticky = (op == OP_SBC) | (op == OP_CPC);
  assign bw_use = sticky & c_in;
  assign sum9 = {1'b0, a} + {1'b0, b} + {8'd0, cy_use};
  assign sum5 = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cy_use};
  assign dif9 = {1'b0, a} - {1'b0, b} - {8'd0, bw_use};
  assign dif5 = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'd0, bw_use};
  assign is_logic = (op == OP_AND) | (op == OP_OR) | (op == OP_XOR) | (op == OP_CBR);

  always_comb begin
    y = a; c = 1'b0; h = 1'b0; v = 1'b0; m = 6'h00; res_we = 1'b1;
    case (op)
      OP_ADD, OP_ADC: begin
        y = sum9[7:0]; c = sum9[8]; h = sum5[4]; m = M_ALL;
        v = (a[7] == b[7]) & (sum9[7] != a[7]);
      end
      OP_SUB, OP_SBC, OP_CP, OP_CPC: begin
        y = dif9[7:0]; c = dif9[8]; h = dif5[4]; m = M_ALL;
        v = (a[7] != b[7]) & (dif9[7] != a[7]);
        res_we = (op == OP_SUB) | (op == OP_SBC);
      end
      OP_AND: begin y = a & b;  m = M_ZNVS; end
      OP_OR:  begin y = a | b;  m = M_ZNVS; end
      OP_XOR: begin y = a ^ b;  m = M_ZNVS; end
      OP_CBR: begin y = a & ~b; m = M_ZNVS; end
      OP_COM: begin y = ~a; c = 1'b1; m = M_NOH; end
      OP_NEG: begin
        y = 8'd0 - a; c = |a; h = |a[3:0]; v = (a == 8'h80); m = M_ALL;
      end
      OP_INC: begin y = a + 8'd1; v = (a == 8'h7F); m = M_ZNVS; end
      OP_DEC: begin y = a - 8'd1; v = (a == 8'h80); m = M_ZNVS; end
      OP_LSR: begin y = {1'b0, a[7:1]};   c = a[0]; v = c; m = M_NOH; end
      OP_ASR: begin y = {a[7], a[7:1]};   c = a[0]; v = a[7] ^ c; m = M_NOH; end
      OP_ROR: begin y = {c_in, a[7:1]};   c = a[0]; v = c_in ^ c; m = M_NOH; end
      OP_ROL: begin y = {a[6:0], c_in};   c = a[7]; v = a[6] ^ c; m = M_NOH; end
      OP_LSL: begin y = {a[6:0], 1'b0};   c = a[7]; v = a[6] ^ c; m = M_NOH; end
      OP_SWP: begin y = {a[3:0], a[7:4]}; end
      default: res_we = 1'b0;
    endcase
  end

  assign n = y[7];
  assign z = (y == 8'd0) & (~sticky | z_in);
  assign res = y;
  assign flag_we = m;
  assign flags = {h, n ^ v, v, n, z, c} & m;

  always_comb begin
    if (op == OP_CP || op == OP_CPC)
      a_r3_cmp_no_write: assert (!res_we) else $error("compare wrote result");
    if (op == OP_SWP)
      a_r9_swap_flags: assert (flag_we == 6'h00 && res_we) else $error("swap touched flags");
    if (is_logic)
      a_r4_keep_c_h: assert (!flag_we[0] && !flag_we[5] && !flags[3]) else $error("logic op C/H/V");
    if (flag_we[3])
      a_r10_sign_with_v: assert (flag_we[4]) else $error("V written without S");
    if (flag_we[1] && !sticky)
      a_r1_zero_matches: assert (flags[1] == (res == 8'd0)) else $error("Z mismatch");
    if (op > OP_CBR)
      a_r11_unused_idle: assert (!res_we && flag_we == 6'h00) else $error("unused code active");
  end
endmodule

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [4:0] op;
  logic [7:0] a, b;
  logic c_in, z_in;
  logic [7:0] res;
  logic res_we;
  logic [5:0] flags, flag_we;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  alu8_flags uut (.op(op), .a(a), .b(b), .c_in(c_in), .z_in(z_in),
                  .res(res), .res_we(res_we), .flags(flags), .flag_we(flag_we));

  function automatic string req_of(int o);
    if (o <= 1) return "R1";
    if (o <= 3) return "R2";
    if (o <= 5) return "R3";
    if (o <= 8 || o == 19) return "R4";
    if (o == 9) return "R5";
    if (o == 10) return "R6";
    if (o <= 12) return "R7";
    if (o <= 17) return "R8";
    if (o == 18) return "R9";
    return "R11";
  endfunction

  function automatic int sgn(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // returns {we, mask, flags, result}
  function automatic logic [20:0] model(int o, int x, int y, int ci, int zi);
    int r, yy, sr, cc;
    bit c, h, v, n, z, s, we;
    logic [5:0] mk;
    c = 0; h = 0; v = 0; we = 1; mk = 6'h00; yy = x; z = 1;
    case (o)
      0, 1: begin
        cc = (o == 1) ? ci : 0;
        r = x + y + cc; yy = r % 256; c = r > 255;
        h = (x % 16 + y % 16 + cc) > 15;
        sr = sgn(x) + sgn(y) + cc; v = (sr > 127) || (sr < -128); mk = 6'h3F;
      end
      2, 3, 4, 5: begin
        cc = (o == 3 || o == 5) ? ci : 0;
        r = x - y - cc; yy = (r + 512) % 256; c = r < 0;
        h = (x % 16 - y % 16 - cc) < 0;
        sr = sgn(x) - sgn(y) - cc; v = (sr > 127) || (sr < -128); mk = 6'h3F;
        we = (o < 4);
        if (o == 3 || o == 5) z = (zi != 0);
      end
      6:  begin yy = x & y; mk = 6'h1E; end
      7:  begin yy = x | y; mk = 6'h1E; end
      8:  begin yy = x ^ y; mk = 6'h1E; end
      19: begin yy = x & (255 - y); mk = 6'h1E; end
      9:  begin yy = 255 - x; c = 1; mk = 6'h1F; end
      10: begin yy = (256 - x) % 256; c = x != 0; h = (x % 16) != 0; v = x == 128; mk = 6'h3F; end
      11: begin yy = (x + 1) % 256; v = x == 127; mk = 6'h1E; end
      12: begin yy = (x + 255) % 256; v = x == 128; mk = 6'h1E; end
      13: begin yy = x / 2; c = x % 2; mk = 6'h1F; end
      14: begin yy = x / 2 + ((x >= 128) ? 128 : 0); c = x % 2; mk = 6'h1F; end
      15: begin yy = x / 2 + ci * 128; c = x % 2; mk = 6'h1F; end
      16: begin yy = (x * 2) % 256 + ci; c = x >= 128; mk = 6'h1F; end
      17: begin yy = (x * 2) % 256; c = x >= 128; mk = 6'h1F; end
      18: begin yy = (x % 16) * 16 + x / 16; end
      default: we = 0;
    endcase
    n = yy >= 128;
    if (o >= 13 && o <= 17) v = n ^ c;
    s = n ^ v;
    z = z && (yy == 0);
    return {we, mk, ({h, s, v, n, z, c} & mk), yy[7:0]};
  endfunction

  task automatic check_now(int o, string tag);
    logic [20:0] exp, got;
    exp = model(o, a, b, c_in, z_in);
    got = {res_we, flag_we, flags, res};
    checks++;
    if (got !== exp) begin
      fails++;
      if (fails < 20)
        $display("FAIL %s op=%0d a=%h b=%h c=%0d z=%0d actual we/mask/flags/res=%b/%h/%h/%h expected %b/%h/%h/%h",
                 tag, o, a, b, c_in, z_in, got[20], got[19:14], got[13:8], got[7:0],
                 exp[20], exp[19:14], exp[13:8], exp[7:0]);
    end
  endtask

  initial begin
    op = 5'd31; a = 8'h00; b = 8'h00; c_in = 0; z_in = 0;
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    check_now(31, "R11");               // idle unused code at start
    // R2 sticky zero: SBC 0x10-0x10 with z_in clear must leave Z at 0
    op = 5'd3; a = 8'h10; b = 8'h10; c_in = 0; z_in = 0; #2;
    check_now(3, "R2");
    // R6 boundary 0x80
    op = 5'd10; a = 8'h80; #2; check_now(10, "R6");
    // R7 boundaries
    op = 5'd11; a = 8'h7F; #2; check_now(11, "R7");
    op = 5'd12; a = 8'h80; #2; check_now(12, "R7");
    for (int o = 0; o < 32; o++) begin
      for (int x = 0; x < 256; x++) begin
        for (int yi = 0; yi < 16; yi++) begin
          for (int k = 0; k < 4; k++) begin
            op = o[4:0]; a = x[7:0]; b = 8'(yi * 17 + (x % 3)); c_in = k[0]; z_in = k[1];
            #2;
            check_now(o, (o < 20 && flag_we[3]) ? {req_of(o), "/R10"} : req_of(o));
          end
        end
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule